// File: doc/BRIEF.md
# Multi-Stage Lockable Watchdog Controller

The block is a watchdog with its own periodic timer. The timer decrements on a one-microsecond tick enable. Each time it underflows it sends an expiry pulse. The watchdog counts pulses from a tick source chosen by software: either its own timer or one of several external timer pulses. Each time a programmed number of pulses has been seen, the watchdog moves to the next expiration stage.

The first two stages can raise a level interrupt. The third stage stops the watchdog and can emit a single-cycle reset request to the reset controller. Software keeps the system alive by writing the start command again (a ping). That write clears the stage count, the countdown and the timer count.

A disable command takes effect only when the key value 0xC45A was written to the unlock register just before it. Any command write uses up an earlier unlock. A read-only status word shows the live countdown, the stage and whether the watchdog is running.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` and `rst_req` are low, and the watchdog is stopped.
- R2: The timer register sits at offset 0x10. Its fields are: bit 31 enable, bit 30 periodic, bits [29:0] reload count. Writing the register loads the timer count from the reload value. While enabled, each `us_tick` decrements the count. The timer fires on the tick that finds the count at 1 or 0, so the period is the reload value in ticks. On firing it reloads. In one-shot mode (bit 30 clear), firing also clears bit 31. With bit 31 clear, the timer count holds and the timer never fires.
- R3: The configuration register sits at offset 0x0 and holds the period at bits [11:4]. The status register sits at offset 0x4 and shows the countdown at bits [11:4]. Start loads the countdown with the period, or with 1 when the period is 0. While running, each selected tick decrements the countdown. The tick that finds the countdown at 1 is an expiration, and it reloads the countdown.
- R4: The status register shows the stage at bits [13:12] and the running flag at bit 0. Each expiration increments the stage. The third expiration sets the stage to 3 and stops the watchdog. It also gives a one-cycle `rst_req` when configuration bit 15 is set.
- R5: An expiration to stage 1 or 2 sets the level output `irq` when configuration bit 12 is set. `irq` clears on a start command or on an accepted disable.
- R6: Writing the command register (offset 0x8) with bit 0 set starts or pings the watchdog. It sets running, clears the stage, reloads the countdown and reloads the timer count.
- R7: Command bit 1 stops the watchdog only if the last write to the unlock register (offset 0xC) was 0x0000C45A and no command write came in between. Otherwise bit 1 is ignored. When both bits are set and the unlock is valid, the disable wins.
- R8: Every command write clears the unlock state, whatever its value.
- R9: Configuration bits [3:0] select the tick source. The value LOCAL_ID (default 0) selects the internal timer. Any other ID below NUM_SRC (default 4) selects `ext_tick` bit ID. IDs of NUM_SRC or more select nothing.
- R10: The command and unlock registers read zero. The configuration register reads back only bits [15], [12] and [11:0] (mask 0x9FFF). The timer register reads back its enable, periodic and reload fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| us_tick | input | 1 | One-microsecond tick enable for the internal timer |
| ext_tick | input | NUM_SRC | Expiry pulses from other timers |
| irq | output | 1 | Level interrupt for intermediate stages |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- a reset request lasts one cycle and appears only at stage 3 with the watchdog stopped;
- the final stage always means the watchdog is stopped;
- the countdown is never zero while running;
- a ping always clears `irq`;
- a command write always uses up the unlock;
- a locked disable leaves the watchdog running.

Only the directed scenarios can show the numeric behaviour: the timer period in ticks, one-shot self-disable, the countdown sequence, the routing of the source selection, and the need for the exact key value.

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int ADDR_W   = 5,
  parameter int NUM_SRC  = 4,
  parameter int LOCAL_ID = 0,
  parameter int RELOAD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              us_tick,
  input  logic [NUM_SRC-1:0] ext_tick,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_UNL = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(16);
  localparam logic [31:0] KEY      = 32'h0000_C45A;
  localparam logic [31:0] CFG_MASK = 32'h0000_9FFF;
  localparam logic [RELOAD_W-1:0] T_ONE = RELOAD_W'(1);

  logic [31:0]         cfg_q;
  logic                t_en, t_per;
  logic [RELOAD_W-1:0] t_rld, t_cnt;
  logic                run_q, unl_q, irq_q, rst_q;
  logic [1:0]          exp_q;
  logic [7:0]          cnt_q;

  wire wr_cfg = bus_wr && bus_addr == A_CFG;
  wire wr_cmd = bus_wr && bus_addr == A_CMD;
  wire wr_unl = bus_wr && bus_addr == A_UNL;
  wire wr_tmr = bus_wr && bus_addr == A_TMR;

  wire do_dis   = wr_cmd && bus_wdata[1] && unl_q;
  wire do_start = wr_cmd && bus_wdata[0] && !do_dis;

  wire t_fire = us_tick && t_en && (t_cnt <= T_ONE);

  wire [3:0] src_id = cfg_q[3:0];
  wire [7:0] ld_val = (cfg_q[11:4] == 8'd0) ? 8'd1 : cfg_q[11:4];

  logic [NUM_SRC-1:0] src_vec;
  logic               sel_tick;
  always_comb begin
    src_vec = ext_tick;
    src_vec[LOCAL_ID] = t_fire;
    sel_tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_id == 4'(i) && src_vec[i]) sel_tick = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_en <= 1'b0; t_per <= 1'b0; t_rld <= '0; t_cnt <= '0;
    end else if (wr_tmr) begin
      t_en  <= bus_wdata[31];
      t_per <= bus_wdata[30];
      t_rld <= bus_wdata[RELOAD_W-1:0];
      t_cnt <= bus_wdata[RELOAD_W-1:0];
    end else if (do_start) begin
      t_cnt <= t_rld;
    end else if (us_tick && t_en) begin
      if (t_cnt <= T_ONE) begin
        t_cnt <= t_rld;
        if (!t_per) t_en <= 1'b0;
      end else begin
        t_cnt <= t_cnt - T_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; run_q <= 1'b0; unl_q <= 1'b0; irq_q <= 1'b0;
      rst_q <= 1'b0; exp_q <= 2'd0; cnt_q <= 8'd0;
    end else begin
      rst_q <= 1'b0;
      if (wr_cfg) cfg_q <= bus_wdata & CFG_MASK;
      if (wr_unl) unl_q <= (bus_wdata == KEY);
      if (wr_cmd) unl_q <= 1'b0;
      if (do_start) begin
        run_q <= 1'b1; exp_q <= 2'd0; cnt_q <= ld_val; irq_q <= 1'b0;
      end else if (do_dis) begin
        run_q <= 1'b0; irq_q <= 1'b0;
      end else if (run_q && sel_tick) begin
        if (cnt_q <= 8'd1) begin
          cnt_q <= ld_val;
          exp_q <= exp_q + 2'd1;
          if (exp_q == 2'd2) begin
            run_q <= 1'b0;
            rst_q <= cfg_q[15];
          end else begin
            irq_q <= irq_q | cfg_q[12];
          end
        end else begin
          cnt_q <= cnt_q - 8'd1;
        end
      end
    end
  end

  logic [31:0] tmr_rd;
  always_comb begin
    tmr_rd = '0;
    tmr_rd[31] = t_en;
    tmr_rd[30] = t_per;
    tmr_rd[RELOAD_W-1:0] = t_rld;
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_q;
      A_STS:   bus_rdata = {18'd0, exp_q, cnt_q, 3'd0, run_q};
      A_TMR:   bus_rdata = tmr_rd;
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = irq_q;
  assign rst_req = rst_q;
endmodule

module wdog_ctrl_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              run_q,
  input logic              unl_q,
  input logic              irq,
  input logic              rst_req,
  input logic [1:0]        exp_q,
  input logic [7:0]        cnt_q
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(8);
  wire cmd_wr = bus_wr && bus_addr == A_CMD;

  a_r4_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r4_rst_final: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (exp_q == 2'd3 && !run_q));
  a_r4_final_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q == 2'd3) |-> !run_q);
  a_r3_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != 8'd0));
  a_r5_irq_ping: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[0]) |=> !irq);
  a_r5_irq_stage: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (exp_q != 2'd0));
  a_r8_unlock_used: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !unl_q);
  a_r7_locked_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[1] && !bus_wdata[0] && !unl_q && run_q && exp_q != 2'd2) |=> run_q);
endmodule

bind wdog_ctrl wdog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run_q(run_q), .unl_q(unl_q), .irq(irq),
  .rst_req(rst_req), .exp_q(exp_q), .cnt_q(cnt_q)
);

// File: tb/test_wdog_ctrl.sv
module test_wdog_ctrl;
  localparam int ADDR_W = 5;
  localparam int NUM_SRC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic us_tick = 1'b0;
  logic [NUM_SRC-1:0] ext_tick = '0;
  logic irq, rst_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdog_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) i_wdog_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .us_tick(us_tick),
    .ext_tick(ext_tick), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      us_tick = 1'b1;
    end
    @(negedge clk);
    us_tick = 1'b0;
  endtask

  task automatic ext(input logic [NUM_SRC-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ext_tick = v;
    end
    @(negedge clk);
    ext_tick = '0;
  endtask

  function automatic logic [31:0] sts(input int e, input int c, input int r);
    return 32'((e << 12) | (c << 4) | r);
  endfunction

  task automatic chk_sts(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(5'd4, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'd0, d);  chk("R1 cfg reset", d, 0);
    rd(5'd16, d); chk("R1 timer reset", d, 0);
    chk_sts("R1 status reset", 0);
    chk("R1 irq reset", {31'd0, irq}, 0);
    chk("R1 rst_req reset", {31'd0, rst_req}, 0);
  endtask

  task automatic t_reads();
    logic [31:0] d;
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, d);  chk("R10 cfg mask", d, 32'h0000_9FFF);
    wr(5'd12, 32'h0000_C45A);
    rd(5'd12, d); chk("R10 unlock reads zero", d, 0);
    wr(5'd8, 32'h0);
    rd(5'd8, d);  chk("R10 cmd reads zero", d, 0);
    wr(5'd16, 32'hC000_0005);
    rd(5'd16, d); chk("R10 timer readback", d, 32'hC000_0005);
  endtask

  task automatic t_stages();
    wr(5'd0, 32'h0000_9010);
    wr(5'd16, 32'hC000_0003);
    wr(5'd8, 32'h1);
    chk_sts("R6 start status", sts(0, 1, 1));
    tick(2);
    chk_sts("R2 no fire before period", sts(0, 1, 1));
    tick(1);
    chk_sts("R4 stage 1", sts(1, 1, 1));
    chk("R5 irq at stage 1", {31'd0, irq}, 1);
    tick(3);
    chk_sts("R4 stage 2", sts(2, 1, 1));
    tick(2);
    chk("R4 no early rst_req", {31'd0, rst_req}, 0);
    tick(1);
    chk("R4 rst_req at final", {31'd0, rst_req}, 1);
    chk_sts("R4 final stopped", sts(3, 1, 0));
    @(negedge clk);
    chk("R4 rst_req one cycle", {31'd0, rst_req}, 0);
    tick(6);
    chk_sts("R4 final holds", sts(3, 1, 0));
  endtask

  task automatic t_countdown();
    wr(5'd0, 32'h0000_0030);
    wr(5'd16, 32'hC000_0001);
    wr(5'd8, 32'h1);
    chk_sts("R3 load period", sts(0, 3, 1));
    tick(1); chk_sts("R3 count 2", sts(0, 2, 1));
    tick(1); chk_sts("R3 count 1", sts(0, 1, 1));
    tick(1); chk_sts("R3 expire reload", sts(1, 3, 1));
    chk("R5 irq off when disabled", {31'd0, irq}, 0);
  endtask

  task automatic t_ping_disable();
    wr(5'd0, 32'h0000_1010);
    wr(5'd16, 32'hC000_0002);
    wr(5'd8, 32'h1);
    tick(3);
    chk_sts("R4 stage 1 before ping", sts(1, 1, 1));
    chk("R5 irq before ping", {31'd0, irq}, 1);
    wr(5'd8, 32'h1);
    chk("R5 irq cleared by ping", {31'd0, irq}, 0);
    chk_sts("R6 ping clears stage", sts(0, 1, 1));
    tick(1);
    chk_sts("R6 ping reloads timer", sts(0, 1, 1));
    tick(1);
    chk_sts("R6 fire after reload", sts(1, 1, 1));
    wr(5'd8, 32'h2);
    chk_sts("R7 locked disable ignored", sts(1, 1, 1));
    wr(5'd12, 32'h0000_1234);
    wr(5'd8, 32'h2);
    chk_sts("R7 wrong key ignored", sts(1, 1, 1));
    wr(5'd12, 32'h0000_C45A);
    wr(5'd8, 32'h2);
    chk_sts("R7 unlocked disable", sts(1, 1, 0));
    chk("R5 irq cleared by disable", {31'd0, irq}, 0);
    tick(4);
    chk_sts("R7 stopped no stages", sts(1, 1, 0));
  endtask

  task automatic t_consume();
    wr(5'd0, 32'h0000_0010);
    wr(5'd16, 32'hC000_0004);
    wr(5'd8, 32'h1);
    wr(5'd12, 32'h0000_C45A);
    wr(5'd8, 32'h0);
    wr(5'd8, 32'h2);
    chk_sts("R8 unlock consumed", sts(0, 1, 1));
    wr(5'd12, 32'h0000_C45A);
    wr(5'd8, 32'h3);
    chk_sts("R7 disable wins over start", sts(0, 1, 0));
  endtask

  task automatic t_timer();
    logic [31:0] d;
    wr(5'd0, 32'h0000_0010);
    wr(5'd16, 32'h4000_0002);
    wr(5'd8, 32'h1);
    tick(5);
    chk_sts("R2 disabled timer holds", sts(0, 1, 1));
    wr(5'd16, 32'h8000_0002);
    tick(2);
    chk_sts("R2 one-shot fires", sts(1, 1, 1));
    rd(5'd16, d); chk("R2 one-shot clears enable", d, 32'h0000_0002);
    tick(6);
    chk_sts("R2 one-shot fires once", sts(1, 1, 1));
  endtask

  task automatic t_source();
    wr(5'd0, 32'h0000_0012);
    wr(5'd16, 32'hC000_0001);
    wr(5'd8, 32'h1);
    tick(3);
    chk_sts("R9 internal timer unselected", sts(0, 1, 1));
    ext(4'b0010, 1);
    chk_sts("R9 other ext ignored", sts(0, 1, 1));
    ext(4'b0100, 1);
    chk_sts("R9 ext source 2", sts(1, 1, 1));
    wr(5'd0, 32'h0000_0019);
    wr(5'd8, 32'h1);
    ext(4'b1111, 3);
    tick(3);
    chk_sts("R9 out of range source", sts(0, 1, 1));
  endtask

  task automatic t_norst();
    wr(5'd0, 32'h0000_0010);
    wr(5'd16, 32'hC000_0001);
    wr(5'd8, 32'h1);
    tick(2);
    chk_sts("R4 stage 2 no rst_en", sts(2, 1, 1));
    tick(1);
    chk("R4 no rst_req when disabled", {31'd0, rst_req}, 0);
    chk_sts("R4 final without reset", sts(3, 1, 0));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reads();
    t_stages();
    t_countdown();
    t_ping_disable();
    t_consume();
    t_timer();
    t_source();
    t_norst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule